// File: doc/BRIEF.md
# Self-Trigger Hit Register for a 72-Channel Front End

This block is the digital half of the self-triggering path of a multi-channel detector front end. Every channel delivers one asynchronous discriminator bit. Each channel can be masked on its own. The rising edge of an unmasked pulse marks that channel in a sticky hit register. The block also computes two quantities every clock from the unmasked inputs that are high: a global trigger, which is the OR of those inputs, and a multiplicity, which is how many of them are high.

A four-wire serial configuration port gives access to a 2-bit setting per channel and to the hit register. Through this port the acquisition system finds out which channels fired after a trigger. A separate clear strobe empties the hit register between events. A test-pulse input lets the system fire selected channels without a detector signal.

Top module: `chan_hit_trigger`

## Requirements
- R1: After `rst_n` is low, `trig_out` is 0, `mult_out` is 0 and every hit bit is 0. Every channel setting reads back as 0, so no channel is masked and no channel is test-enabled.
- R2: A hit bit is set on a 0-to-1 transition of its channel's effective input. The effective input is the discriminator bit ORed with the injected test pulse, then forced to 0 when the channel is masked. A level that stays high does not set a bit again.
- R3: A hit bit stays set until `hit_clr` is high for a clock or `rst_n` is low. When `hit_clr` and a new edge land in the same cycle, the clear wins and the bit reads 0.
- R4: Setting bit 0 of a channel's setting masks that channel. A masked channel never sets its hit bit and contributes to neither `trig_out` nor `mult_out`.
- R5: `trig_out` is the OR of the effective inputs of all channels. It follows an input change at the third rising clock edge after the change: two synchronizer stages, then one output register.
- R6: `mult_out` is a 7-bit count, from 0 to 72, of the effective inputs that are high. It has the same latency as `trig_out`.
- R7: Bit 1 of a channel's setting enables test injection for that channel. While `test_pulse` is high, such a channel behaves as if its discriminator were high, and bit 0 can still mask it.
- R8: A frame starts when `sc_cs_n` goes low. Bits are sampled on rising edges of `sc_clk`, most significant bit first. The first 8 bits are a command: bit 7 is 1 for a read and 0 for a write, and bits 6:0 are the address. The next 8 bits are data. A write to addresses 0 to 71 loads data bits 1:0 into that channel's setting. A write to any other address changes nothing.
- R9: A read returns 8 bits on `sc_dout`, one valid at each rising `sc_clk` edge of the data phase, most significant bit first. Addresses 0 to 71 return the channel setting in bits 1:0 and zeros above. Address 72+g returns the hits of channels 8g+7 down to 8g in bits 7 down to 0. The hits are captured when the command byte completes. Any other address returns 0.
- R10: `sc_dout` is 0 whenever `sc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 72 | Asynchronous per-channel discriminator bits |
| test_pulse | input | 1 | Test injection strobe for test-enabled channels |
| hit_clr | input | 1 | Synchronous clear of the hit register |
| sc_cs_n | input | 1 | Serial port select, active low |
| sc_clk | input | 1 | Serial port bit clock |
| sc_din | input | 1 | Serial data in |
| sc_dout | output | 1 | Serial data out |
| trig_out | output | 1 | OR of the effective inputs |
| mult_out | output | 7 | Count of the effective inputs that are high |

## Verification
The hardest case to reach from the ports is a new discriminator edge that arrives in exactly the cycle `hit_clr` is sampled. The synchronizer hides the internal timing, so the bench raises one channel and raises `hit_clr` two clock edges later. This makes the clear coincide with the edge register. The bench then reads the hit register back over the serial port and expects the bit to be empty.

Masking is checked the same way. Masked channels are included in vectors that also drive unmasked neighbours. Their hit bits are confirmed empty through serial readback of every hit group.

// File: rtl/cht_pkg.sv
package cht_pkg;
  localparam int CFG_W   = 2;   // per-channel setting width
  localparam int CFG_MASK = 0;  // bit position of the mask
  localparam int CFG_TEST = 1;  // bit position of the test enable

  // number of serial bytes needed to cover a vector of n bits
  function automatic int groups_for(input int n, input int w);
    return (n + w - 1) / w;
  endfunction
endpackage

// File: rtl/cht_sync.sv
module cht_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cht_hit_core.sv
module cht_hit_core #(
  parameter int NCH = 72,
  parameter int MULT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    disc_s,
  input  logic              tp_s,
  input  logic [NCH-1:0]    mask,
  input  logic [NCH-1:0]    ten,
  input  logic              hit_clr,
  output logic [NCH-1:0]    hits,
  output logic              trig,
  output logic [MULT_W-1:0] mult
);
  // population count of the live channels
  function automatic logic [MULT_W-1:0] count_live(input logic [NCH-1:0] v);
    logic [MULT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NCH; i++) n = n + MULT_W'(v[i]);
    return n;
  endfunction

  logic [NCH-1:0] live;     // effective per-channel input
  logic [NCH-1:0] live_q;   // previous cycle, for edge detection
  logic [NCH-1:0] edge_up;  // newly rising live channels

  assign live    = (disc_s | ({NCH{tp_s}} & ten)) & ~mask;
  assign edge_up = live & ~live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hits   <= '0;
      trig   <= 1'b0;
      mult   <= '0;
    end else begin
      live_q <= live;
      hits   <= hit_clr ? '0 : (hits | edge_up);
      trig   <= |live;
      mult   <= count_live(live);
    end
  end
endmodule

// File: rtl/cht_serial.sv
module cht_serial
  import cht_pkg::*;
#(
  parameter int NCH = 72,
  parameter int CMD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bclk_s,
  input  logic           csn_s,
  input  logic           din_s,
  input  logic [NCH-1:0] hits,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] ten,
  output logic           cs_act,
  output logic           sdo
);
  localparam int ADDR_W = CMD_W - 1;
  localparam int TOT    = CMD_W + DATA_W;
  localparam int CNT_W  = $clog2(TOT + 1);
  localparam int NGRP   = groups_for(NCH, DATA_W);
  localparam logic [CNT_W-1:0] CNT_CMD_END = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_DAT_END = CNT_W'(TOT - 1);
  localparam logic [CNT_W-1:0] CNT_SHIFT_LO = CNT_W'(CMD_W + 1);
  localparam logic [CNT_W-1:0] CNT_TOT = CNT_W'(TOT);

  logic                  bclk_q, b_rise, b_fall;
  logic [CNT_W-1:0]      cnt;
  logic [CMD_W-1:0]      cmd_sr, cmd_next;
  logic [CFG_W-2:0]      dat_sr;
  logic [CFG_W-1:0]      dat_next;
  logic [DATA_W-1:0]     rd_sr, rd_data;
  logic [NGRP*DATA_W-1:0] hits_pad;
  logic                  cmd_done, wr_done;
  logic [ADDR_W-1:0]     rd_addr, wr_addr;

  assign cs_act   = ~csn_s;
  assign b_rise   = bclk_s & ~bclk_q;
  assign b_fall   = ~bclk_s & bclk_q;
  assign cmd_next = {cmd_sr[CMD_W-2:0], din_s};
  assign dat_next = {dat_sr, din_s};
  assign cmd_done = cs_act & b_rise & (cnt == CNT_CMD_END);
  assign wr_done  = cs_act & b_rise & (cnt == CNT_DAT_END) & ~cmd_sr[CMD_W-1];
  assign rd_addr  = cmd_next[ADDR_W-1:0];
  assign wr_addr  = cmd_sr[ADDR_W-1:0];

  always_comb begin
    hits_pad = '0;
    hits_pad[NCH-1:0] = hits;
  end

  // read multiplexer: channel settings, then hit groups
  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_addr == ADDR_W'(c))
        rd_data = {{(DATA_W-CFG_W){1'b0}}, ten[c], mask[c]};
    for (int g = 0; g < NGRP; g++)
      if (rd_addr == ADDR_W'(NCH + g))
        rd_data = hits_pad[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      cnt    <= '0;
      cmd_sr <= '0;
      dat_sr <= '0;
      rd_sr  <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (!cs_act) begin
        cnt <= '0;
      end else if (b_rise && cnt < CNT_TOT) begin
        cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(CMD_W)) cmd_sr <= cmd_next;
        else dat_sr <= dat_next[CFG_W-2:0];
      end
      if (cmd_done)
        rd_sr <= cmd_next[CMD_W-1] ? rd_data : '0;
      else if (cs_act && b_fall && cnt >= CNT_SHIFT_LO && cnt < CNT_TOT)
        rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      ten  <= '0;
    end else if (wr_done) begin
      for (int c = 0; c < NCH; c++)
        if (wr_addr == ADDR_W'(c)) begin
          mask[c] <= dat_next[CFG_MASK];
          ten[c]  <= dat_next[CFG_TEST];
        end
    end
  end

  assign sdo = cs_act & rd_sr[DATA_W-1];
endmodule

// File: rtl/chan_hit_trigger.sv
module chan_hit_trigger #(
  parameter int NCH = 72,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W = 8,
  parameter int DATA_W = 8,
  localparam int MULT_W = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    disc_in,
  input  logic              test_pulse,
  input  logic              hit_clr,
  input  logic              sc_cs_n,
  input  logic              sc_clk,
  input  logic              sc_din,
  output logic              sc_dout,
  output logic              trig_out,
  output logic [MULT_W-1:0] mult_out
);
  logic [NCH:0]     fe_s;     // synchronized {test_pulse, disc_in}
  logic [2:0]       sc_s;     // synchronized {sc_clk, sc_cs_n, sc_din}
  logic [NCH-1:0]   hit_vec;
  logic [NCH-1:0]   cfg_mask;
  logic [NCH-1:0]   cfg_ten;
  logic             cs_act;

  cht_sync #(.W(NCH+1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_fe_sync (
    .clk(clk), .rst_n(rst_n), .d({test_pulse, disc_in}), .q(fe_s)
  );

  cht_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sc_sync (
    .clk(clk), .rst_n(rst_n), .d({sc_clk, sc_cs_n, sc_din}), .q(sc_s)
  );

  cht_hit_core #(.NCH(NCH), .MULT_W(MULT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .disc_s(fe_s[NCH-1:0]), .tp_s(fe_s[NCH]),
    .mask(cfg_mask), .ten(cfg_ten), .hit_clr(hit_clr),
    .hits(hit_vec), .trig(trig_out), .mult(mult_out)
  );

  cht_serial #(.NCH(NCH), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_sc (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(sc_s[2]), .csn_s(sc_s[1]), .din_s(sc_s[0]),
    .hits(hit_vec), .mask(cfg_mask), .ten(cfg_ten),
    .cs_act(cs_act), .sdo(sc_dout)
  );
endmodule

// File: rtl/cht_checker.sv
module cht_checker #(
  parameter int NCH = 72,
  parameter int MULT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_clr,
  input logic [NCH-1:0]    hits,
  input logic [NCH-1:0]    mask,
  input logic              trig,
  input logic [MULT_W-1:0] mult
);
  // R3: a hit bit only drops after a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((~hits & $past(hits)) != '0) |-> $past(hit_clr));

  // R3: a clear empties the whole register on the next cycle
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> (hits == '0));

  // R4: no new hit appears on a masked channel
  a_r4_masked_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hits & ~$past(hits) & $past(mask)) == '0);

  // R5 with R6: trigger is high exactly when the count is non-zero
  a_r5_trig_vs_mult: assert property (@(posedge clk) disable iff (!rst_n)
    trig == (mult != '0));

  // R6: count never exceeds the channel total
  a_r6_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
    mult <= MULT_W'(NCH));
endmodule

bind chan_hit_trigger cht_checker #(.NCH(NCH), .MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_clr(hit_clr), .hits(hit_vec),
  .mask(cfg_mask), .trig(trig_out), .mult(mult_out)
);

// File: tb/chan_hit_trigger_test.sv
module chan_hit_trigger_test;
  localparam int NCH = 72;
  localparam int H = 6;           // serial half period in system clocks
  localparam int NVEC = 9;
  localparam logic [NCH-1:0] VEC [NVEC] = '{
    72'h0,
    72'h1,
    72'h9,
    72'h40_0000_0000_0000_0000,
    {NCH{1'b1}},
    72'h0,
    {9{8'hAA}},
    {9{8'h55}},
    72'h80_0000_0000_0000_0000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] disc_in = '0;
  logic test_pulse = 1'b0, hit_clr = 1'b0;
  logic sc_cs_n = 1'b1, sc_clk = 1'b0, sc_din = 1'b0;
  logic sc_dout, trig_out;
  logic [6:0] mult_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_hit_trigger uut (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .test_pulse(test_pulse),
    .hit_clr(hit_clr), .sc_cs_n(sc_cs_n), .sc_clk(sc_clk), .sc_din(sc_din),
    .sc_dout(sc_dout), .trig_out(trig_out), .mult_out(mult_out)
  );

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, output logic [7:0] rd);
    logic [15:0] fr;
    fr = {cmd, wd};
    rd = '0;
    sc_cs_n = 1'b0;
    tick(H);
    for (int i = 0; i < 16; i++) begin
      sc_din = fr[15-i];
      tick(H);
      if (i >= 8) rd[15-i] = sc_dout;
      sc_clk = 1'b1;
      tick(H);
      sc_clk = 1'b0;
    end
    tick(H);
    sc_cs_n = 1'b1;
    sc_din = 1'b0;
    tick(H);
  endtask

  task automatic wr_cfg(input int ch, input logic [7:0] d);
    logic [7:0] junk;
    xfer({1'b0, 7'(ch)}, d, junk);
  endtask

  task automatic rd_reg(input int addr, output logic [7:0] d);
    xfer({1'b1, 7'(addr)}, 8'h00, d);
  endtask

  task automatic rd_hits(output logic [NCH-1:0] h);
    logic [7:0] b;
    for (int g = 0; g < 9; g++) begin
      rd_reg(NCH + g, b);
      h[g*8 +: 8] = b;
    end
  endtask

  task automatic pulse_clr;
    hit_clr = 1'b1;
    tick(1);
    hit_clr = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [NCH-1:0] h, exp_hit, inh, prev_live, live;
    tick(3);
    // R1: reset state while reset is held and just after release
    chk("R1 trig", NCH'(trig_out), '0);
    chk("R1 mult", NCH'(mult_out), '0);
    rst_n = 1'b1;
    tick(3);
    chk("R10 dout idle", NCH'(sc_dout), '0);
    rd_reg(0, b);  chk("R1 cfg ch0", NCH'(b), '0);
    rd_reg(71, b); chk("R1 cfg ch71", NCH'(b), '0);
    rd_hits(h);    chk("R1 hits", h, '0);

    // R8: write masks on channels 3 and 70, read back (R9)
    wr_cfg(3, 8'hFD);
    wr_cfg(70, 8'h01);
    rd_reg(3, b);  chk("R8/R9 cfg ch3", NCH'(b), NCH'(8'h01));
    rd_reg(70, b); chk("R9 cfg ch70", NCH'(b), NCH'(8'h01));
    // R8: unmapped write ignored
    wr_cfg(100, 8'h03);
    rd_reg(100, b); chk("R8/R9 unmapped read", NCH'(b), '0);
    rd_reg(28, b);  chk("R8 no alias ch28", NCH'(b), '0);
    rd_reg(36, b);  chk("R8 no alias ch36", NCH'(b), '0);

    // table walk: R2, R4, R5, R6, R9
    inh = '0; inh[3] = 1'b1; inh[70] = 1'b1;
    exp_hit = '0; prev_live = '0;
    for (int v = 0; v < NVEC; v++) begin
      disc_in = VEC[v];
      tick(3);
      live = VEC[v] & ~inh;
      exp_hit = exp_hit | (live & ~prev_live);
      prev_live = live;
      chk("R5 trig", NCH'(trig_out), NCH'(|live));
      chk("R6 mult", NCH'(mult_out), NCH'($countones(live)));
      rd_hits(h);
      chk("R2/R4 hits", h, exp_hit);
    end
    // R10: port idle after reads that returned ones
    chk("R10 dout idle", NCH'(sc_dout), '0);

    // R3: clear empties the register
    disc_in = '0;
    tick(3);
    pulse_clr();
    rd_hits(h); chk("R3 cleared", h, '0);

    // R5/R6 latency: third edge after the change
    disc_in[20] = 1'b1;
    tick(2);
    chk("R6 latency early", NCH'(mult_out), '0);
    tick(1);
    chk("R6 latency on time", NCH'(mult_out), NCH'(1));
    chk("R5 latency on time", NCH'(trig_out), NCH'(1));
    disc_in = '0;
    tick(3);
    pulse_clr();

    // R3: clear coincides with new edge on channel 5
    disc_in[5] = 1'b1;
    tick(2);
    hit_clr = 1'b1;
    tick(1);
    hit_clr = 1'b0;
    tick(2);
    rd_hits(h); chk("R3 clear priority", h, '0);
    disc_in = '0;
    tick(3);
    disc_in[5] = 1'b1;
    tick(3);
    rd_hits(h);
    exp_hit = '0; exp_hit[5] = 1'b1;
    chk("R2 re-arm after clear", h, exp_hit);
    disc_in = '0;
    tick(3);
    pulse_clr();

    // R7: test injection on ch10 (enabled) and ch11 (enabled but masked)
    wr_cfg(10, 8'h02);
    wr_cfg(11, 8'h03);
    test_pulse = 1'b1;
    tick(3);
    chk("R7 mult", NCH'(mult_out), NCH'(1));
    chk("R7 trig", NCH'(trig_out), NCH'(1));
    test_pulse = 1'b0;
    tick(3);
    chk("R7 mult after", NCH'(mult_out), '0);
    rd_hits(h);
    exp_hit = '0; exp_hit[10] = 1'b1;
    chk("R7 hits", h, exp_hit);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule